// File: doc/BRIEF.md
# Cluster-Shared Global Router Arbiter

This block moves one data word from each participating element of a processor array to an element that the sender chooses. The caller presents one batch: an activity mask, one destination index per element and one data word per element, and pulses `start`. Each element may address any element of the array. Destination indices that fall outside the array are reported on an error mask and are not delivered.

The elements are grouped into clusters of sixteen, and each cluster has one port into an ideal crossbar. A cluster therefore sends one word per cycle. Its pending senders are served in round-robin order, which always begins at the lowest member when a batch starts. All clusters work in parallel. When two cluster winners name the same destination in one cycle, the lower-numbered cluster writes first and the other sender tries again in the next cycle. A single-cycle `done` pulse marks the end of the batch. After that pulse, `rx_hit` shows which elements received a word and `rx_data_flat` holds those words.

Top module: `cluster_router`

## Requirements
- R1: After reset, `busy`, `done`, `err_mask`, `rx_hit` and every word of `rx_data_flat` are zero.
- R2: A `start` sampled while idle latches `active`, `dest_flat` and `data_flat` and clears `rx_hit`. `busy` is 1 after that edge if at least one active element has an in-range destination.
- R3: Every active element e whose destination d (bits [e*DEST_W +: DEST_W] of `dest_flat`) satisfies d < N_ELEM has its word written to `rx_data_flat[d*DATA_W +: DATA_W]`, and `rx_hit[d]` is set.
- R4: An active element with d >= N_ELEM sets `err_mask[e]` at the start edge and is not delivered. `err_mask` holds until the next accepted start.
- R5: An element whose `active` bit is 0 delivers nothing and raises no error.
- R6: A cluster (elements c*16 to c*16+15) delivers at most one word per cycle. Within a batch its senders go in ascending element order, so after the first delivery edge exactly the lowest pending member of each cluster has been delivered, apart from losers under R7.
- R7: When cluster winners name the same destination in one cycle, the lowest-numbered cluster writes. The others stay pending and retry in the next cycle, so the higher cluster's word is the one left at that destination.
- R8: If the batch needs K delivery cycles, the deliveries occur on edges 1 to K after the start edge and `done` is 1 for exactly one cycle, following edge K+1. With no destination conflicts, K is the largest count of deliverable requests in any one cluster.
- R9: A `start` pulse while `busy` is 1 is ignored and does not change the outcome of the batch in progress.
- R10: A batch with no deliverable request leaves `busy` at 0 and raises `done` after the first edge following the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a batch (honoured only while idle) |
| active | input | N_ELEM | Per-element participation mask |
| dest_flat | input | N_ELEM*DEST_W | Per-element destination index, DEST_W = log2(N_ELEM)+1 |
| data_flat | input | N_ELEM*DATA_W | Per-element data word |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle completion pulse |
| err_mask | output | N_ELEM | Active senders with out-of-range destinations |
| rx_hit | output | N_ELEM | Destinations written in the current batch |
| rx_data_flat | output | N_ELEM*DATA_W | Received word per element |

## Verification
The bench targets four kinds of batch, each with a specific failure in mind:
- A full cluster of sixteen senders, which must take exactly sixteen cycles. A design that paid no attention to cluster sharing would finish too early.
- Cross-cluster collisions on one destination. An arbiter that dropped the loser, or that let the wrong cluster write last, leaves a missing hit or a stale word.
- Out-of-range indices and inactive senders mixed with legal traffic. A design that wrapped the index would corrupt a real element.
- An empty batch, and a `start` pulse injected mid-batch. Wrong completion timing, or re-latching while busy, shows up as a latency mismatch or as data from the second pulse.

// File: rtl/router_pkg.sv
package router_pkg;

    localparam int unsigned CLUSTER_SIZE = 16;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    function automatic logic idx_in_range(input logic [31:0] idx, input int unsigned limit);
        return idx < limit;
    endfunction

endpackage

// File: rtl/rr_cluster_pick.sv
module rr_cluster_pick #(
    parameter int unsigned CS = 16,
    localparam int unsigned PW = $clog2(CS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CS-1:0] req,
    input  logic          advance,
    output logic          pick_valid,
    output logic [PW-1:0] pick_idx
);
    logic [PW-1:0] ptr_q;

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = 0; i < int'(CS); i++) begin
            logic [PW-1:0] k;
            k = PW'((int'(ptr_q) + i) % int'(CS));
            if (!pick_valid && req[k]) begin
                pick_valid = 1'b1;
                pick_idx   = k;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= PW'((int'(pick_idx) + 1) % int'(CS));
        end
    end

    // R6: the chosen member must really be waiting
    always_ff @(posedge clk) begin
        if (!rst && pick_valid) begin
            a_r6_pick_pending: assert (req[pick_idx]);
        end
    end

    // R6: a winner is only retired when it was picked
    a_r6_advance_needs_pick: assert property (@(posedge clk) disable iff (rst)
        advance |-> pick_valid);

endmodule

// File: rtl/dest_claim_resolve.sv
module dest_claim_resolve #(
    parameter int unsigned NC = 4,
    parameter int unsigned DW = 7
) (
    input  logic [NC-1:0]    valid,
    input  logic [NC*DW-1:0] dest_flat,
    output logic [NC-1:0]    allow
);
    always_comb begin
        for (int c = 0; c < int'(NC); c++) begin
            allow[c] = valid[c];
            for (int p = 0; p < c; p++) begin
                if (valid[p] && dest_flat[p*DW +: DW] == dest_flat[c*DW +: DW]) begin
                    allow[c] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cluster_router.sv
module cluster_router
    import router_pkg::*;
#(
    parameter int unsigned N_ELEM = 64,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W  = $clog2(N_ELEM),
    localparam int unsigned DEST_W = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [N_ELEM-1:0]        active,
    input  logic [N_ELEM*DEST_W-1:0] dest_flat,
    input  logic [N_ELEM*DATA_W-1:0] data_flat,
    output logic                     busy,
    output logic                     done,
    output logic [N_ELEM-1:0]        err_mask,
    output logic [N_ELEM-1:0]        rx_hit,
    output logic [N_ELEM*DATA_W-1:0] rx_data_flat
);
    localparam int unsigned N_CL = N_ELEM / CLUSTER_SIZE;
    localparam int unsigned PW   = $clog2(CLUSTER_SIZE);

    phase_t              phase_q;
    logic                last_q, done_q;
    logic [N_ELEM-1:0]   pend_q, pend_nxt, err_q, hit_q, in_ok;
    logic [DEST_W-1:0]   dst_q [N_ELEM];
    logic [DATA_W-1:0]   dat_q [N_ELEM];
    logic [DATA_W-1:0]   rx_q  [N_ELEM];
    logic [DEST_W-1:0]   in_dest [N_ELEM];
    logic [DATA_W-1:0]   in_data [N_ELEM];

    logic [N_CL-1:0]        pick_v, allow;
    logic [PW-1:0]          pick_i   [N_CL];
    logic [IDX_W-1:0]       cand_src [N_CL];
    logic [N_CL*DEST_W-1:0] cand_dest_flat;
    logic                   accept;

    assign accept = start && (phase_q == PH_IDLE);

    always_comb begin
        for (int e = 0; e < int'(N_ELEM); e++) begin
            in_dest[e] = dest_flat[e*DEST_W +: DEST_W];
            in_data[e] = data_flat[e*DATA_W +: DATA_W];
            in_ok[e]   = idx_in_range(32'(in_dest[e]), N_ELEM);
        end
    end

    generate
        for (genvar c = 0; c < int'(N_CL); c++) begin : g_cluster
            rr_cluster_pick #(.CS(CLUSTER_SIZE)) u_pick (
                .clk        (clk),
                .rst        (rst),
                .restart    (accept),
                .req        (pend_q[c*CLUSTER_SIZE +: CLUSTER_SIZE]),
                .advance    (allow[c]),
                .pick_valid (pick_v[c]),
                .pick_idx   (pick_i[c])
            );
            assign cand_src[c] = IDX_W'(c * CLUSTER_SIZE) + IDX_W'(pick_i[c]);
            assign cand_dest_flat[c*DEST_W +: DEST_W] = dst_q[cand_src[c]];
        end
    endgenerate

    dest_claim_resolve #(.NC(N_CL), .DW(DEST_W)) u_resolve (
        .valid     (pick_v),
        .dest_flat (cand_dest_flat),
        .allow     (allow)
    );

    always_comb begin
        pend_nxt = pend_q;
        for (int c = 0; c < int'(N_CL); c++) begin
            if (allow[c]) pend_nxt[cand_src[c]] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            pend_q  <= '0;
            err_q   <= '0;
            hit_q   <= '0;
            for (int e = 0; e < int'(N_ELEM); e++) begin
                dst_q[e] <= '0;
                dat_q[e] <= '0;
                rx_q[e]  <= '0;
            end
        end else begin
            done_q <= last_q;
            last_q <= 1'b0;
            if (accept) begin
                pend_q <= active & in_ok;
                err_q  <= active & ~in_ok;
                hit_q  <= '0;
                for (int e = 0; e < int'(N_ELEM); e++) begin
                    dst_q[e] <= in_dest[e];
                    dat_q[e] <= in_data[e];
                end
                if ((active & in_ok) == '0) last_q  <= 1'b1;
                else                        phase_q <= PH_RUN;
            end else if (phase_q == PH_RUN) begin
                pend_q <= pend_nxt;
                for (int c = 0; c < int'(N_CL); c++) begin
                    if (allow[c]) begin
                        rx_q[IDX_W'(dst_q[cand_src[c]])]  <= dat_q[cand_src[c]];
                        hit_q[IDX_W'(dst_q[cand_src[c]])] <= 1'b1;
                    end
                end
                if (pend_nxt == '0) begin
                    phase_q <= PH_IDLE;
                    last_q  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int e = 0; e < int'(N_ELEM); e++) rx_data_flat[e*DATA_W +: DATA_W] = rx_q[e];
    end

    assign busy     = (phase_q == PH_RUN);
    assign done     = done_q;
    assign err_mask = err_q;
    assign rx_hit   = hit_q;

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion only once nothing is left to send
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && pend_q == '0));

    // R9: no request can appear while a batch is running
    a_r9_no_new_pending: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((pend_q & ~$past(pend_q)) == '0));

    // R4: an erroneous sender is never queued
    a_r4_err_not_pending: assert property (@(posedge clk) disable iff (rst)
        (pend_q & err_q) == '0);

    // R3: hits accumulate within a batch
    a_r3_hit_monotone: assert property (@(posedge clk) disable iff (rst)
        busy |=> (($past(hit_q) & ~hit_q) == '0));

    // R7: two clusters never write one destination in the same cycle
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int a = 0; a < int'(N_CL); a++) begin
                for (int b = a + 1; b < int'(N_CL); b++) begin
                    if (allow[a] && allow[b]) begin
                        a_r7_one_writer: assert (dst_q[cand_src[a]] != dst_q[cand_src[b]]);
                    end
                end
            end
        end
    end

endmodule

// File: tb/cluster_router_test.sv
module cluster_router_test;
    localparam int N  = 64;
    localparam int DW = 8;
    localparam int TW = 7;
    localparam int CS = 16;
    localparam int NC = N / CS;

    logic clk = 1'b0;
    logic rst, start;
    logic [N-1:0]    active;
    logic [N*TW-1:0] dest_flat;
    logic [N*DW-1:0] data_flat;
    logic busy, done;
    logic [N-1:0]    err_mask, rx_hit;
    logic [N*DW-1:0] rx_data_flat;

    always #4 clk = ~clk;

    cluster_router #(.N_ELEM(N), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .start(start), .active(active),
        .dest_flat(dest_flat), .data_flat(data_flat), .busy(busy), .done(done),
        .err_mask(err_mask), .rx_hit(rx_hit), .rx_data_flat(rx_data_flat)
    );

    int checks = 0;
    int errors = 0;

    logic [N-1:0]  b_act;
    logic [TW-1:0] b_dest [N];
    logic [DW-1:0] b_data [N];
    logic [N-1:0]  exp_hit, exp_hit1, exp_err;
    logic [DW-1:0] exp_data [N];
    int            exp_k;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act_v, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act_v, exp_v);
        end
    endtask

    task automatic pack();
        active = b_act;
        for (int e = 0; e < N; e++) begin
            dest_flat[e*TW +: TW] = b_dest[e];
            data_flat[e*DW +: DW] = b_data[e];
        end
    endtask

    // schedule model built from R3..R8
    task automatic model();
        logic [N-1:0] pend;
        logic [N-1:0] claimed;
        pend    = '0;
        exp_err = '0;
        exp_hit = '0;
        exp_hit1 = '0;
        exp_k   = 0;
        for (int e = 0; e < N; e++) begin
            exp_data[e] = '0;
            if (b_act[e] && b_dest[e] < TW'(N)) pend[e] = 1'b1;
            if (b_act[e] && b_dest[e] >= TW'(N)) exp_err[e] = 1'b1;
        end
        while (pend != '0) begin
            exp_k++;
            claimed = '0;
            for (int c = 0; c < NC; c++) begin
                bit found;
                found = 1'b0;
                for (int j = 0; j < CS; j++) begin
                    int e;
                    int d;
                    e = c*CS + j;
                    if (!found && pend[e]) begin
                        found = 1'b1;
                        d = int'(b_dest[e]);
                        if (!claimed[d]) begin
                            claimed[d]  = 1'b1;
                            exp_data[d] = b_data[e];
                            exp_hit[d]  = 1'b1;
                            pend[e]     = 1'b0;
                        end
                    end
                end
            end
            if (exp_k == 1) exp_hit1 = exp_hit;
        end
    endtask

    // mode 1: inject a start pulse while busy (R9)
    task automatic run_batch(input string tag, input int mode);
        int m;
        pack();
        model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m = 1;
        chk(busy == (exp_k > 0), "R2", {tag, " busy after start"}, 64'(busy), 64'(exp_k > 0));
        if (exp_k == 0) chk(busy == 1'b0, "R10", {tag, " empty stays idle"}, 64'(busy), 64'd0);
        while (!done && m < 200) begin
            @(negedge clk);
            m++;
            if (m == 2 && exp_k >= 1)
                chk(rx_hit == exp_hit1, "R6", {tag, " first-cycle deliveries"}, rx_hit, exp_hit1);
            if (mode == 1 && m == 2 && exp_k >= 2) begin
                active    = ~b_act;
                data_flat = ~data_flat;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (exp_k == 0)
            chk(m == 2, "R10", {tag, " empty latency"}, 64'(m - 1), 64'd1);
        else
            chk(m == exp_k + 2, "R8", {tag, " done latency"}, 64'(m - 1), 64'(exp_k + 1));
        chk(err_mask == exp_err, "R4", {tag, " error mask"}, err_mask, exp_err);
        chk(rx_hit == exp_hit, mode == 1 ? "R9" : "R3", {tag, " hit mask"}, rx_hit, exp_hit);
        for (int d = 0; d < N; d++) begin
            if (exp_hit[d])
                chk(rx_data_flat[d*DW +: DW] == exp_data[d], mode == 1 ? "R9" : "R3",
                    {tag, " word"}, 64'(rx_data_flat[d*DW +: DW]), 64'(exp_data[d]));
        end
        @(negedge clk);
        chk(done == 1'b0, "R8", {tag, " done width"}, 64'(done), 64'd0);
    endtask

    task automatic clear_batch();
        b_act = '0;
        for (int e = 0; e < N; e++) begin
            b_dest[e] = TW'(e);
            b_data[e] = DW'(e + 8'h40);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20250417));
        rst = 1'b1;
        start = 1'b0;
        clear_batch();
        pack();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done", {62'd0, busy, done}, 64'd0);
        chk(err_mask == '0, "R1", "err_mask", err_mask, 64'd0);
        chk(rx_hit == '0, "R1", "rx_hit", rx_hit, 64'd0);
        chk(rx_data_flat == '0, "R1", "rx_data", 64'(rx_data_flat), 64'd0);

        // R10 empty batch
        clear_batch();
        run_batch("empty", 0);

        // R6 R8 full cluster: 16 cycles
        clear_batch();
        for (int e = 0; e < CS; e++) begin
            b_act[e] = 1'b1;
            b_dest[e] = TW'(63 - e);
        end
        run_batch("full cluster", 0);

        // R7 collision between cluster 0 and cluster 1
        clear_batch();
        b_act[0] = 1'b1; b_dest[0] = 7'd30; b_data[0] = 8'hA1;
        b_act[16] = 1'b1; b_dest[16] = 7'd30; b_data[16] = 8'hB2;
        run_batch("collision", 0);
        chk(rx_data_flat[30*DW +: DW] == 8'hB2, "R7", "higher cluster last",
            64'(rx_data_flat[30*DW +: DW]), 64'hB2);

        // R4 R5 out-of-range and inactive senders
        clear_batch();
        b_act[5] = 1'b1; b_dest[5] = 7'd64;
        b_act[6] = 1'b1; b_dest[6] = 7'd127;
        b_act[7] = 1'b1; b_dest[7] = 7'd12; b_data[7] = 8'h5C;
        b_dest[8] = 7'd20;
        run_batch("range", 0);
        chk(rx_hit[20] == 1'b0 && err_mask[8] == 1'b0, "R5", "inactive sender silent",
            {62'd0, rx_hit[20], err_mask[8]}, 64'd0);

        // R9 start while busy
        clear_batch();
        for (int e = 0; e < N; e += 3) begin
            b_act[e] = 1'b1;
            b_dest[e] = TW'($urandom_range(0, 63));
            b_data[e] = DW'($urandom);
        end
        run_batch("restart ignored", 1);

        // random batches
        for (int t = 0; t < 24; t++) begin
            int pct;
            int hot;
            pct = int'($urandom_range(10, 100));
            hot = int'($urandom_range(0, 2));
            for (int e = 0; e < N; e++) begin
                b_act[e] = ($urandom_range(0, 99) < pct);
                if ($urandom_range(0, 19) == 0)   b_dest[e] = TW'($urandom_range(64, 127));
                else if (hot == 0)                b_dest[e] = TW'($urandom_range(0, 7));
                else                              b_dest[e] = TW'($urandom_range(0, 63));
                b_data[e] = DW'($urandom);
            end
            run_batch($sformatf("random %0d", t), (t % 4 == 3) ? 1 : 0);
        end

        summary();
        $finish;
    end
endmodule